// File: doc/BRIEF.md
# Bulk-Commit Transmit Buffer with Watermark Events

This block is a transmit buffer that sits between a fast producer and a slow hardware consumer. The producer does not push words through a queue port. It writes words straight into the storage array by slot address. Those words stay invisible to the consumer until the producer commits them by moving the write pointer. A commit either adds a word count to the pointer or jumps the pointer so that the buffer is full in one step. The consumer drains one word per read strobe and receives the data, with a valid flag, one cycle later.

The producer decides when to refill from two status signals, `full` and `tide`, and from both pointers. In FIFO mode `tide` is a level: it is high while the free space is at or above a programmable watermark, so the producer knows a burst write fits. In block mode `tide` is a one-cycle pulse. It fires each time a power-of-two block of words has been drained, which means a block of space has been freed. Two sticky bits record misuse: an advance that asks for more than the free space, and a read of an empty buffer. Only reset clears them.

Top module: `wb_xmit_buf`

## Requirements
- R1: After reset both pointers are 0, `full`, `cons_valid`, `adv_err` and `underflow` are low, and the drained-word count used in block mode is 0.
- R2: `full` is high exactly when the committed word count (`wr_ptr - rd_ptr` modulo 2·DEPTH) equals DEPTH, which is when the two pointers differ only in their top (wrap) bit.
- R3: With `prod_we` high, `prod_wdata` is stored at slot `prod_addr` on the clock edge if that slot holds no committed unread word. The stored word is not visible to the consumer until a commit covers it: a read strobe before the commit returns no valid data.
- R4: A producer write to a slot that holds a committed unread word is ignored, and that word is later read out unchanged.
- R5: A command with `cmd_valid` high and `cmd_op` = 0 (advance) adds `cmd_count` to `wr_ptr` in one cycle when `cmd_count` is no larger than the free space.
- R6: An advance whose `cmd_count` exceeds the free space moves `wr_ptr` only by the free space, so the buffer becomes full, and sets `adv_err`. `adv_err` then stays high until reset.
- R7: A command with `cmd_op` = 1 (fill) sets `wr_ptr` to `rd_ptr` with the top bit inverted. With no read in the same cycle, `full` is high on the next cycle.
- R8: `cons_rd` on a non-empty buffer raises `cons_valid` for one cycle on the next cycle, with `cons_data` holding the oldest committed word, and increments `rd_ptr`. Words come out in slot order from `rd_ptr`.
- R9: `cons_rd` on an empty buffer leaves `cons_valid` low and `rd_ptr` unchanged on the next cycle, and sets `underflow`. `underflow` stays high until reset.
- R10: With `mode_block` = 0, `tide` is high exactly when the free space (DEPTH minus the committed count) is greater than or equal to `tide_level`.
- R11: With `mode_block` = 1, `tide` is a one-cycle pulse. It is high in the cycle where `cons_valid` rises for a read that brings the number of words drained since reset to a multiple of 2^`blk_log2`. `blk_log2` values above 16 are treated as 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_we | input | 1 | Producer direct write enable |
| prod_addr | input | ADDR_W | Storage slot for the direct write |
| prod_wdata | input | DATA_W | Word for the direct write |
| cmd_valid | input | 1 | Pointer command strobe |
| cmd_op | input | 1 | 0 = advance by count, 1 = fill to full |
| cmd_count | input | ADDR_W+1 | Word count for advance |
| mode_block | input | 1 | 0 = watermark level, 1 = block pulse |
| tide_level | input | ADDR_W+1 | Free-space watermark for FIFO mode |
| blk_log2 | input | 5 | log2 of the block size for block mode |
| cons_rd | input | 1 | Consumer read strobe |
| cons_data | output | DATA_W | Word read by the consumer |
| cons_valid | output | 1 | `cons_data` is valid this cycle |
| full | output | 1 | No free slot remains |
| tide | output | 1 | Watermark level or block-drained pulse |
| wr_ptr | output | ADDR_W+1 | Write pointer including the wrap bit |
| rd_ptr | output | ADDR_W+1 | Read pointer including the wrap bit |
| adv_err | output | 1 | Sticky: an advance was clamped |
| underflow | output | 1 | Sticky: a read hit an empty buffer |

## Verification
The pointer logic is driven through a chain of advance, fill and read-burst steps. The chain includes an exact-fit advance, an over-large advance that must clamp, and a fill taken while the read pointer sits past the wrap. Together these separate correct wrap-bit handling from plain modulo arithmetic. The data path is tried with words written before their commit, with a write aimed at a slot that is already committed, and with a write into a still-free slot. This shows that visibility depends only on the commit and that live data is protected. The tide output is tried at the watermark itself and one word past it, and in block mode with block sizes of one word, four words and a capped size that never completes within the run.

// File: rtl/wb_pkg.sv
package wb_pkg;
    // Pointer command encodings
    typedef enum logic {
        CMD_ADVANCE = 1'b0,
        CMD_FILL    = 1'b1
    } wb_cmd_e;

    // Width of the block-size control field and of the drained-word counter
    localparam int BLK_FIELD_W = 5;
    localparam int BLK_CNT_W   = 16;
endpackage

// File: rtl/wb_store.sv
module wb_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    // Storage array: one direct write port, one registered read port
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata_q <= mem[raddr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/wb_ptrs.sv
module wb_ptrs
    import wb_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    input  logic [ADDR_W:0]   cmd_count,
    input  logic              rd_req,
    output logic              wr_accept,
    output logic              rd_fire,
    output logic [ADDR_W:0]   wr_ptr,
    output logic [ADDR_W:0]   rd_ptr,
    output logic [ADDR_W:0]   free_cnt,
    output logic              full,
    output logic              cons_valid,
    output logic              adv_err,
    output logic              underflow
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic             vld;
        logic             adv_err;
        logic             udf;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    logic [PTR_W-1:0]  used_w;
    logic [PTR_W-1:0]  free_w;
    logic [ADDR_W-1:0] offs_w;
    logic              occupied_w;
    logic              empty_w;

    always_comb begin
        used_w     = st_q.wr - st_q.rd;
        free_w     = DEPTH_P - used_w;
        empty_w    = (used_w == '0);
        offs_w     = wr_addr - st_q.rd[ADDR_W-1:0];
        occupied_w = ({1'b0, offs_w} < used_w);
        rd_fire    = rd_req && !empty_w;

        st_d     = st_q;
        st_d.vld = rd_fire;
        if (rd_fire) begin
            st_d.rd = st_q.rd + PTR_W'(1);
        end
        if (rd_req && empty_w) begin
            st_d.udf = 1'b1;
        end
        if (cmd_valid) begin
            if (cmd_op == CMD_FILL) begin
                st_d.wr = {~st_q.rd[ADDR_W], st_q.rd[ADDR_W-1:0]};
            end else if (cmd_count > free_w) begin
                st_d.wr      = st_q.wr + free_w;
                st_d.adv_err = 1'b1;
            end else begin
                st_d.wr = st_q.wr + cmd_count;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_accept  = wr_en && !occupied_w;
    assign wr_ptr     = st_q.wr;
    assign rd_ptr     = st_q.rd;
    assign free_cnt   = free_w;
    assign full       = (used_w == DEPTH_P);
    assign cons_valid = st_q.vld;
    assign adv_err    = st_q.adv_err;
    assign underflow  = st_q.udf;

    AST_SPAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        PTR_W'(wr_ptr - rd_ptr) <= DEPTH_P); // R6
    AST_FILL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_FILL && !rd_req) |=> full); // R7
    AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> (rd_ptr == $past(rd_ptr) + PTR_W'(1)) && cons_valid); // R8
    AST_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wr_ptr == rd_ptr) |=> (!cons_valid && $stable(rd_ptr) && underflow)); // R9
    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        adv_err |=> adv_err); // R6
endmodule

// File: rtl/wb_tide.sv
module wb_tide
    import wb_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode_block,
    input  logic [ADDR_W:0]        tide_level,
    input  logic [BLK_FIELD_W-1:0] blk_log2,
    input  logic [ADDR_W:0]        free_cnt,
    input  logic                   rd_fire,
    output logic                   tide
);
    localparam int CW = BLK_CNT_W;
    localparam logic [BLK_FIELD_W-1:0] LOG2_CAP = BLK_FIELD_W'(CW);

    typedef struct packed {
        logic [CW-1:0] drained;
        logic          pulse;
    } tide_state_t;

    tide_state_t st_d, st_q;

    logic [BLK_FIELD_W-1:0] k_w;
    logic [CW-1:0]          mask_w;
    logic [CW-1:0]          nxt_w;

    always_comb begin
        k_w    = (blk_log2 > LOG2_CAP) ? LOG2_CAP : blk_log2;
        mask_w = ~({CW{1'b1}} << k_w);
        nxt_w  = st_q.drained + CW'(1);

        st_d       = st_q;
        st_d.pulse = rd_fire && ((nxt_w & mask_w) == '0);
        if (rd_fire) begin
            st_d.drained = nxt_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tide = mode_block ? st_q.pulse : (free_cnt >= tide_level);

    AST_BLK_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_block && tide) |-> $past(rd_fire)); // R11
endmodule

// File: rtl/wb_xmit_buf.sv
module wb_xmit_buf
    import wb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   prod_we,
    input  logic [ADDR_W-1:0]      prod_addr,
    input  logic [DATA_W-1:0]      prod_wdata,
    input  logic                   cmd_valid,
    input  logic                   cmd_op,
    input  logic [ADDR_W:0]        cmd_count,
    input  logic                   mode_block,
    input  logic [ADDR_W:0]        tide_level,
    input  logic [BLK_FIELD_W-1:0] blk_log2,
    input  logic                   cons_rd,
    output logic [DATA_W-1:0]      cons_data,
    output logic                   cons_valid,
    output logic                   full,
    output logic                   tide,
    output logic [ADDR_W:0]        wr_ptr,
    output logic [ADDR_W:0]        rd_ptr,
    output logic                   adv_err,
    output logic                   underflow
);
    logic            wr_accept;
    logic            rd_fire;
    logic [ADDR_W:0] free_cnt;

    wb_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (prod_we),
        .wr_addr    (prod_addr),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_count  (cmd_count),
        .rd_req     (cons_rd),
        .wr_accept  (wr_accept),
        .rd_fire    (rd_fire),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .free_cnt   (free_cnt),
        .full       (full),
        .cons_valid (cons_valid),
        .adv_err    (adv_err),
        .underflow  (underflow)
    );

    wb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (wr_accept),
        .waddr (prod_addr),
        .wdata (prod_wdata),
        .re    (rd_fire),
        .raddr (rd_ptr[ADDR_W-1:0]),
        .rdata (cons_data)
    );

    wb_tide #(.ADDR_W(ADDR_W)) u_tide (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_block (mode_block),
        .tide_level (tide_level),
        .blk_log2   (blk_log2),
        .free_cnt   (free_cnt),
        .rd_fire    (rd_fire),
        .tide       (tide)
    );

    AST_FULL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_accept); // R4
endmodule

// File: tb/tb_wb_xmit_buf.sv
module tb_wb_xmit_buf;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              prod_we;
    logic [ADDR_W-1:0] prod_addr;
    logic [DATA_W-1:0] prod_wdata;
    logic              cmd_valid;
    logic              cmd_op;
    logic [ADDR_W:0]   cmd_count;
    logic              mode_block;
    logic [ADDR_W:0]   tide_level;
    logic [4:0]        blk_log2;
    logic              cons_rd;
    logic [DATA_W-1:0] cons_data;
    logic              cons_valid;
    logic              full;
    logic              tide;
    logic [ADDR_W:0]   wr_ptr;
    logic [ADDR_W:0]   rd_ptr;
    logic              adv_err;
    logic              underflow;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    wb_xmit_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .prod_we(prod_we), .prod_addr(prod_addr),
        .prod_wdata(prod_wdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_count(cmd_count), .mode_block(mode_block), .tide_level(tide_level),
        .blk_log2(blk_log2), .cons_rd(cons_rd), .cons_data(cons_data),
        .cons_valid(cons_valid), .full(full), .tide(tide), .wr_ptr(wr_ptr),
        .rd_ptr(rd_ptr), .adv_err(adv_err), .underflow(underflow)
    );

    // Vector: op[22] count[21:17] reads[16:12] exp_wr[11:7] exp_rd[6:2] exp_full[1] exp_err[0]
    localparam logic [22:0] VECS [8] = '{
        {1'b0, 5'd5,  5'd0,  5'd5,  5'd0,  1'b0, 1'b0},
        {1'b0, 5'd3,  5'd2,  5'd8,  5'd2,  1'b0, 1'b0},
        {1'b1, 5'd0,  5'd0,  5'd18, 5'd2,  1'b1, 1'b0},
        {1'b0, 5'd0,  5'd4,  5'd18, 5'd6,  1'b0, 1'b0},
        {1'b0, 5'd20, 5'd0,  5'd22, 5'd6,  1'b1, 1'b1},
        {1'b0, 5'd0,  5'd16, 5'd22, 5'd22, 1'b0, 1'b1},
        {1'b1, 5'd0,  5'd0,  5'd6,  5'd22, 1'b1, 1'b1},
        {1'b0, 5'd1,  5'd0,  5'd6,  5'd22, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; prod_we = 1'b0; prod_addr = '0; prod_wdata = '0;
        cmd_valid = 1'b0; cmd_op = 1'b0; cmd_count = '0; cons_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_cmd(input logic op, input int cnt);
        cmd_valid = 1'b1; cmd_op = op; cmd_count = 5'(cnt);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_write(input int addr, input int data);
        prod_we = 1'b1; prod_addr = 4'(addr); prod_wdata = 8'(data);
        @(negedge clk);
        prod_we = 1'b0;
    endtask

    task automatic do_read();
        cons_rd = 1'b1;
        @(negedge clk);
        cons_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        mode_block = 1'b0; tide_level = 5'd16; blk_log2 = 5'd0;
        do_reset();

        // R1 reset state, R10 tide at full free space
        chk("R1 wr_ptr", int'(wr_ptr), 0);
        chk("R1 rd_ptr", int'(rd_ptr), 0);
        chk("R1 full", int'(full), 0);
        chk("R1 cons_valid", int'(cons_valid), 0);
        chk("R1 adv_err", int'(adv_err), 0);
        chk("R1 underflow", int'(underflow), 0);
        chk("R10 tide at free=16 level=16", int'(tide), 1);

        // Table walk: R5 advance, R6 clamp, R7 fill, R2 full
        for (int v = 0; v < 8; v++) begin
            do_cmd(VECS[v][22], int'(VECS[v][21:17]));
            for (int r = 0; r < int'(VECS[v][16:12]); r++) do_read();
            chk($sformatf("R5/R7 wr_ptr vec %0d", v), int'(wr_ptr), int'(VECS[v][11:7]));
            chk($sformatf("R8 rd_ptr vec %0d", v), int'(rd_ptr), int'(VECS[v][6:2]));
            chk($sformatf("R2 full vec %0d", v), int'(full), int'(VECS[v][1]));
            chk($sformatf("R6 adv_err vec %0d", v), int'(adv_err), int'(VECS[v][0]));
        end

        // R3 invisibility, R9 empty read
        do_reset();
        for (int i = 0; i < 4; i++) do_write(i, 8'hA0 + i);
        do_read();
        chk("R3 uncommitted read valid", int'(cons_valid), 0);
        chk("R9 rd_ptr unchanged", int'(rd_ptr), 0);
        chk("R9 underflow set", int'(underflow), 1);
        do_cmd(1'b0, 4);
        // R4 write into committed slot ignored; free slot accepted
        do_write(1, 8'hEE);
        do_write(4, 8'h5A);
        do_cmd(1'b0, 1);
        for (int i = 0; i < 5; i++) begin
            do_read();
            chk($sformatf("R8 valid word %0d", i), int'(cons_valid), 1);
            chk($sformatf("R3/R4 data word %0d", i), int'(cons_data),
                (i == 4) ? 8'h5A : 8'hA0 + i);
        end
        @(negedge clk);
        chk("R8 valid single cycle", int'(cons_valid), 0);
        chk("R9 underflow sticky", int'(underflow), 1);

        // R10 watermark boundaries
        do_reset();
        tide_level = 5'd10;
        do_cmd(1'b0, 6);
        chk("R10 tide free=10 level=10", int'(tide), 1);
        do_cmd(1'b0, 1);
        chk("R10 tide free=9 level=10", int'(tide), 0);
        tide_level = 5'd9;
        #1;
        chk("R10 tide free=9 level=9", int'(tide), 1);

        // R11 block pulses, block of 4
        do_reset();
        mode_block = 1'b1; blk_log2 = 5'd2;
        do_cmd(1'b0, 12);
        chk("R11 no pulse before reads", int'(tide), 0);
        for (int i = 0; i < 12; i++) begin
            do_read();
            chk($sformatf("R11 pulse after read %0d", i + 1), int'(tide),
                ((i + 1) % 4 == 0) ? 1 : 0);
        end
        @(negedge clk);
        chk("R11 pulse one cycle", int'(tide), 0);
        blk_log2 = 5'd0;
        do_cmd(1'b0, 2);
        do_read();
        chk("R11 pulse block of 1", int'(tide), 1);
        blk_log2 = 5'd31;
        do_read();
        chk("R11 capped block no pulse", int'(tide), 0);

        finish_run();
    end
endmodule